// File: doc/BRIEF.md
# Timer Compare Unit with Deferred Output

A 16-bit up-counting timer feeds a bank of compare channels. Each channel drives one output pin. The count advances in one of three ways: on every enabled tick (timer), once per rising edge of an external event input (event counter), or on enabled ticks only while a gate input is high (gated timer). When an increment carries the count from 0xFFFF to 0x0000, a sticky overflow flag is set.

Each channel holds a 16-bit compare value, a shadow bit and a pin register. Software writes the shadow bit. The pin takes that value only when the count equals the channel's compare value, so output edges stay lined up with the timer and cannot glitch. The timer, compare values, shadow bits, run/mode control and overflow clear are all reached through one byte-wide write port.

Write map, 5-bit address:

| Address | Function |
|---------|----------|
| 0 | Control: bit 0 is run; bits 2:1 are the mode (0 timer, 1 event, 2 gated, 3 halt) |
| 1 | Writing with bit 0 set clears the overflow flag |
| 2 | Count low byte |
| 3 | Count high byte |
| 4 | Shadow bits, channel c in bit c |
| 8+2c | Channel c compare low byte |
| 9+2c | Channel c compare high byte |

Top module: `tcu_top`

## Requirements
- R1: After reset the count, the compare values, the shadow bits, the pins, the overflow flag and run are all zero. While run is 0 the count does not advance, whatever tick_i does.
- R2: In timer mode (mode 0) with run set, the count rises by exactly one on each clock edge where tick_i is high.
- R3: In gated mode (mode 2) with run set, the count rises by one on each clock edge where tick_i and gate_i are both high, and holds on every other edge.
- R4: In event mode (mode 1) with run set, the count rises by one for each rising edge of event_i. The edge is seen after a two-stage synchronizer. A level held high adds only one.
- R5: An increment from 0xFFFF to 0x0000 sets ovf_o on the same clock edge as the wrap.
- R6: ovf_o stays set until a write to address 1 with bit 0 set. If that clear and a new wrap fall on the same edge, the flag stays set.
- R7: A write to the shadow bits leaves cmp_pin_o unchanged while the count differs from the channel's compare value.
- R8: While a channel's count equals its compare value, its pin loads the shadow bit on the next clock edge. Each channel does this on its own.
- R9: A write to address 2 or 3 loads that byte of the count and leaves the other byte unchanged. On that edge the write takes priority over an increment.
- R10: A write to a compare byte takes effect on its clock edge. From the next cycle, matches are tested against the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | Count enable for timer and gated modes |
| gate_i | input | 1 | Gate level for gated mode |
| event_i | input | 1 | Asynchronous event input for event mode |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| cmp_pin_o | output | 4 | Compare output pins, one per channel |

## Verification
The hardest case to reach is a rollover and an overflow clear landing on the same edge. The bench first loads 0xFFFF through the two count byte writes. It then raises tick_i in the same cycle as the clear write, so the set-wins rule is tested directly.

Deferred pin updates are swept over a range of counts in both directions. The pins are set to one as the count passes each channel's compare value. The shadow bits are then zeroed while the count is away from every match, and the pins must clear one at a time during a second pass.

A separate test writes a compare value equal to the count the timer is stopped at. This checks the one-cycle path from a compare write to the match and then to the pin.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_EVENT = 2'd1,
    MODE_GATED = 2'd2,
    MODE_HALT  = 2'd3
  } cnt_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
  localparam logic [ADDR_W-1:0] A_OVFCLR = 5'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 5'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 5'd3;
  localparam logic [ADDR_W-1:0] A_SHADOW = 5'd4;
  localparam int unsigned       A_CMP0   = 8;
endpackage

// File: rtl/tcu_event_sync.sv
module tcu_event_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], event_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R4: a detected edge never repeats on the next cycle
  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tcu_counter.sv
module tcu_counter
  import tcu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  cnt_mode_e        mode_i,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             evt_rise_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             step;
  logic             load;
  logic             wrap;

  always_comb begin
    unique case (mode_i)
      MODE_TIMER: step = tick_i;
      MODE_EVENT: step = evt_rise_i;
      MODE_GATED: step = tick_i & gate_i;
      default:    step = 1'b0;
    endcase
    step = step & run_i;
  end

  assign load = wr_lo_i | wr_hi_i;
  assign wrap = step & ~load & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q <= {cnt_q[CNT_W-1:BYTE_W], wr_byte_i};
    end else if (wr_hi_i) begin
      cnt_q <= {wr_byte_i, cnt_q[BYTE_W-1:0]};
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  p_hold_stopped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load) |=> $stable(cnt_q));
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i == MODE_TIMER && tick_i && !load) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_gate_low_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_GATED && !gate_i && !load) |=> $stable(cnt_q));
  p_ovf_on_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load && cnt_q == '1) |=> (ovf_q && cnt_q == '0));
  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: rtl/tcu_channel.sv
module tcu_channel
  import tcu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_cmp_lo_i,
  input  logic              wr_cmp_hi_i,
  input  logic              wr_shadow_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              shadow_bit_i,
  output logic              pin_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             shadow_q;
  logic             pin_q;
  logic             match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else if (wr_cmp_lo_i) begin
      cmp_q <= {cmp_q[CNT_W-1:BYTE_W], wr_byte_i};
    end else if (wr_cmp_hi_i) begin
      cmp_q <= {wr_byte_i, cmp_q[BYTE_W-1:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          shadow_q <= 1'b0;
    else if (wr_shadow_i) shadow_q <= shadow_bit_i;
  end

  assign match = (count_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pin_q <= 1'b0;
    else if (match) pin_q <= shadow_q;
  end

  assign pin_o = pin_q;

  p_pin_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != cmp_q) |=> $stable(pin_q));
  p_pin_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == cmp_q) |=> pin_q == $past(shadow_q));
  p_cmp_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp_lo_i |=> cmp_q[BYTE_W-1:0] == $past(wr_byte_i));
endmodule

// File: rtl/tcu_top.sv
module tcu_top
  import tcu_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              event_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o,
  output logic [N_CH-1:0]   cmp_pin_o
);
  logic      run_q;
  cnt_mode_e mode_q;
  logic      evt_rise;
  logic      wr_ctrl;
  logic      wr_shadow;
  logic      unused_data;

  assign wr_ctrl     = wr_en_i && wr_addr_i == A_CTRL;
  assign wr_shadow   = wr_en_i && wr_addr_i == A_SHADOW;
  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= MODE_TIMER;
    end else if (wr_ctrl) begin
      run_q  <= wr_data_i[0];
      mode_q <= cnt_mode_e'(wr_data_i[2:1]);
    end
  end

  tcu_event_sync #(.STAGES(2)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (event_i),
    .rise_o  (evt_rise)
  );

  tcu_counter i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .mode_i     (mode_q),
    .tick_i     (tick_i),
    .gate_i     (gate_i),
    .evt_rise_i (evt_rise),
    .wr_lo_i    (wr_en_i && wr_addr_i == A_CNT_LO),
    .wr_hi_i    (wr_en_i && wr_addr_i == A_CNT_HI),
    .wr_byte_i  (wr_data_i),
    .ovf_clr_i  (wr_en_i && wr_addr_i == A_OVFCLR && wr_data_i[0]),
    .count_o    (count_o),
    .ovf_o      (ovf_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(A_CMP0 + 2*c);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(A_CMP0 + 2*c + 1);

    tcu_channel i_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .count_i      (count_o),
      .wr_cmp_lo_i  (wr_en_i && wr_addr_i == LO_ADDR),
      .wr_cmp_hi_i  (wr_en_i && wr_addr_i == HI_ADDR),
      .wr_shadow_i  (wr_shadow),
      .wr_byte_i    (wr_data_i),
      .shadow_bit_i (wr_data_i[c]),
      .pin_o        (cmp_pin_o[c])
    );
  end

  p_ctrl_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> run_q == $past(wr_data_i[0]));
endmodule

// File: tb/test_tcu_top.sv
module test_tcu_top;
  localparam int N_CH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b0;
  logic        event_i = 1'b0;
  logic [15:0] count_o;
  logic        ovf_o;
  logic [N_CH-1:0] cmp_pin_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  tcu_top #(.N_CH(N_CH)) i_tcu_top (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .tick_i, .gate_i, .event_i, .count_o, .ovf_o, .cmp_pin_o
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en_i = 1'b1; wr_addr_i = 5'(a); wr_data_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_cnt(int v);
    wr(2, v & 8'hff);
    wr(3, (v >> 8) & 8'hff);
  endtask

  task automatic ticks(int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int exp_cnt;
    int cmpv[N_CH];
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state and no counting while stopped
    chk("R1 count", count_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 pins", cmp_pin_o, 0);
    ticks(5);
    chk("R1 stopped", count_o, 0);

    // R2 timer mode sweep
    wr(0, 8'h01);
    foreach (cmpv[i]) cmpv[i] = 0;
    for (int k = 1; k <= 300; k += 23) begin
      set_cnt(0);
      ticks(k);
      chk("R2 timer", count_o, k);
    end

    // R3 gated mode patterns
    wr(0, 8'h05);
    for (int p = 0; p < 4; p++) begin
      set_cnt(0);
      exp_cnt = 0;
      for (int i = 0; i < 40; i++) begin
        tick_i = (i % 5) != p;
        gate_i = (i % (p + 2)) == 0;
        if (tick_i && gate_i) exp_cnt++;
        @(negedge clk_i);
      end
      tick_i = 0; gate_i = 0;
      chk("R3 gated", count_o, exp_cnt);
    end

    // R4 event mode
    wr(0, 8'h03);
    for (int n = 1; n <= 6; n++) begin
      set_cnt(0);
      for (int e = 0; e < n; e++) begin
        event_i = 1; repeat (3) @(negedge clk_i);
        event_i = 0; repeat (3) @(negedge clk_i);
      end
      repeat (4) @(negedge clk_i);
      chk("R4 events", count_o, n);
    end
    set_cnt(0);
    event_i = 1; repeat (20) @(negedge clk_i);
    chk("R4 level held", count_o, 1);
    event_i = 0; repeat (4) @(negedge clk_i);

    // R5 / R6 overflow
    wr(0, 8'h01);
    set_cnt(16'hfffd);
    ticks(2);
    chk("R5 no early ovf", ovf_o, 0);
    chk("R5 at max", count_o, 16'hffff);
    ticks(1);
    chk("R5 ovf set", ovf_o, 1);
    chk("R5 wrapped", count_o, 0);
    ticks(3);
    chk("R6 sticky", ovf_o, 1);
    wr(1, 8'h00);
    chk("R6 bit0 zero ignored", ovf_o, 1);
    wr(1, 8'h01);
    chk("R6 cleared", ovf_o, 0);
    set_cnt(16'hffff);
    tick_i = 1;
    wr(1, 8'h01);
    tick_i = 0;
    chk("R6 set wins", ovf_o, 1);
    chk("R6 count", count_o, 0);
    wr(1, 8'h01);
    chk("R6 cleared again", ovf_o, 0);

    // R7 / R8 deferred pin updates
    set_cnt(0);
    for (int c = 0; c < N_CH; c++) begin
      cmpv[c] = 10 + 5 * c;
      wr(8 + 2 * c, cmpv[c]);
    end
    wr(4, 8'h0f);
    chk("R7 shadow not on pin", cmp_pin_o, 0);
    tick_i = 1;
    for (int i = 0; i < 40; i++) begin
      int e;
      @(negedge clk_i);
      e = 0;
      for (int c = 0; c < N_CH; c++) if (count_o > cmpv[c]) e |= 1 << c;
      chk("R8 rise sweep", cmp_pin_o, e);
    end
    tick_i = 0;
    wr(4, 8'h00);
    chk("R7 pins hold", cmp_pin_o, 4'hf);
    set_cnt(0);
    chk("R7 pins hold after load", cmp_pin_o, 4'hf);
    tick_i = 1;
    for (int i = 0; i < 40; i++) begin
      int e;
      @(negedge clk_i);
      e = 0;
      for (int c = 0; c < N_CH; c++) if (count_o <= cmpv[c]) e |= 1 << c;
      chk("R8 fall sweep", cmp_pin_o, e);
    end
    tick_i = 0;

    // R10 compare write to current count
    wr(4, 8'h0f);
    chk("R7 no match", cmp_pin_o, 0);
    wr(8, count_o & 8'hff);
    chk("R10 not yet", cmp_pin_o, 0);
    @(negedge clk_i);
    chk("R10 new compare matched", cmp_pin_o, 1);

    // R9 byte loads
    tick_i = 1;
    wr(2, 8'h34);
    tick_i = 0;
    chk("R9 low load beats step", count_o, 16'h0034);
    wr(3, 8'h12);
    chk("R9 high load", count_o, 16'h1234);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule